// File: doc/BRIEF.md
# Hash Session Chunking Sequencer

This block stands between a byte stream and a hash engine. It writes each accepted message byte into an external staging RAM of `BUF_BYTES` bytes (4096 by default). It hands the RAM contents to the engine as a chunk only when it has to. A full RAM is not submitted on its own. It goes out when another data byte is actually offered. If the session ends instead, the full RAM becomes the final chunk. While a chunk is with the engine, the input is held off.

A session opens on the first beat that carries data or ends the message. The algorithm select is latched at that point. Only the first chunk of a session is flagged as the start of a hash. Only the last chunk is flagged as the end, and it may be empty. When the last chunk completes, the block returns the engine's digest with the byte order reversed and marks how many bytes are valid. An error response from the engine ends the session and raises an error flag. The flag stays high until the next session opens.

Top module: `hash_chunk_seq`

## Requirements
- R1: After reset, `in_ready` is 1 and `sub_valid`, `dig_valid` and `err_flag` are 0.
- R2: Each accepted data byte is written to the staging RAM in the same cycle, at an address that counts up from 0 within the current chunk.
- R3: A chunk with `sub_term`=0 always has `sub_len` equal to `BUF_BYTES`. It is raised only after a further data byte has been offered while the RAM is full. A full RAM with no further input produces no submission.
- R4: `sub_init` is 1 on the first submission of a session and 0 on every later one.
- R5: The closing submission of a session has `sub_term`=1 and `sub_len` equal to the bytes left over, which may be 0. The request holds steady until `sub_ready`.
- R6: `sub_ctrl1` bits [19:16] hold 0 for SHA-1 (`alg_sel`=0) or 2 for SHA-256 (`alg_sel`=1). All other bits are 0. The value is latched when the session opens.
- R7: On a final completion, `dig_valid` pulses for one cycle. `dig_len` is 20 (SHA-1) or 32 (SHA-256). Byte i of `dig_data` (bits 8i+7:8i) equals byte `dig_len`-1-i of `core_digest`. Bytes at or above `dig_len` are 0.
- R8: A beat with `in_empty`=1 and `in_last`=0 is accepted and has no effect. It does not open a session, does not write the RAM, and does not change the fill count.
- R9: The fill count restarts at 0 after each completed chunk and at each new session.
- R10: A completion with `done_err`=1 ends the session. The block returns to idle with `err_flag`=1, and `err_flag` clears when the next session opens.
- R11: `in_ready` is 0 from the moment a chunk is requested until its completion returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 8 | Message byte |
| in_empty | input | 1 | Beat carries no byte |
| in_last | input | 1 | Beat ends the message |
| alg_sel | input | 1 | 0 SHA-1, 1 SHA-256 |
| buf_we | output | 1 | Staging RAM write enable |
| buf_addr | output | $clog2(BUF_BYTES) | Staging RAM write address |
| buf_wdata | output | 8 | Staging RAM write data |
| sub_valid | output | 1 | Chunk request to engine |
| sub_ready | input | 1 | Engine takes chunk |
| sub_len | output | $clog2(BUF_BYTES+1) | Chunk length in bytes |
| sub_init | output | 1 | First chunk of session |
| sub_term | output | 1 | Closing chunk of session |
| sub_ctrl1 | output | 32 | Engine control word, algorithm in [19:16] |
| done_valid | input | 1 | Engine completion |
| done_err | input | 1 | Completion reports an error |
| core_digest | input | 256 | Engine digest, byte k at bits 8k+7:8k |
| dig_valid | output | 1 | Digest pulse |
| dig_data | output | 256 | Byte-reversed digest |
| dig_len | output | 6 | Valid digest bytes |
| err_flag | output | 1 | Session aborted by engine error |

## Verification
The tightest overlap happens when an engine error arrives while a byte is still waiting behind the full RAM. The abort sends the block to idle. In the very next cycle that waiting byte, flagged as the end of the message, is accepted as the opening of a new session, which clears the error flag. The bench provokes this with a message one byte longer than the RAM, with the first completion marked as an error. It then checks three things: an error was seen, the flag ends low, and a second chunk of length 1 arrives carrying both the start and end flags. A second overlap, a full RAM meeting the end-of-message beat, is judged by checking that exactly one closing chunk of full length is issued.

// File: rtl/hash_chunk_seq.sv
module hash_chunk_seq #(
  parameter int BUF_BYTES = 4096
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [7:0]                     in_data,
  input  logic                           in_empty,
  input  logic                           in_last,
  input  logic                           alg_sel,
  output logic                           buf_we,
  output logic [$clog2(BUF_BYTES)-1:0]   buf_addr,
  output logic [7:0]                     buf_wdata,
  output logic                           sub_valid,
  input  logic                           sub_ready,
  output logic [$clog2(BUF_BYTES+1)-1:0] sub_len,
  output logic                           sub_init,
  output logic                           sub_term,
  output logic [31:0]                    sub_ctrl1,
  input  logic                           done_valid,
  input  logic                           done_err,
  input  logic [255:0]                   core_digest,
  output logic                           dig_valid,
  output logic [255:0]                   dig_data,
  output logic [5:0]                     dig_len,
  output logic                           err_flag
);
  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int DIG_MAX = 32;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_SUB, S_WAIT} st_t;

  st_t           st;
  logic [CW-1:0] fill;
  logic          first_q, term_q, alg_q, err_q, dig_v;
  logic [255:0]  dig_q, rev;
  int            nbytes;

  wire active = (st == S_IDLE) || (st == S_FILL);
  wire full   = (fill == CW'(BUF_BYTES));
  wire acc    = in_valid && in_ready;
  wire skip   = in_empty && !in_last;

  assign in_ready  = active && !(full && !in_empty);
  assign buf_we    = acc && !in_empty;
  assign buf_addr  = fill[AW-1:0];
  assign buf_wdata = in_data;

  assign sub_valid = (st == S_SUB);
  assign sub_len   = fill;
  assign sub_init  = first_q;
  assign sub_term  = term_q;
  assign sub_ctrl1 = {12'd0, (alg_q ? 4'd2 : 4'd0), 16'd0};

  assign dig_valid = dig_v;
  assign dig_data  = dig_q;
  assign dig_len   = alg_q ? 6'd32 : 6'd20;
  assign err_flag  = err_q;
  assign nbytes    = alg_q ? 32 : 20;

  always_comb begin
    rev = '0;
    for (int i = 0; i < DIG_MAX; i++)
      if (i < nbytes) rev[i*8 +: 8] = core_digest[(nbytes-1-i)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fill    <= '0;
      first_q <= 1'b0;
      term_q  <= 1'b0;
      alg_q   <= 1'b0;
      err_q   <= 1'b0;
      dig_v   <= 1'b0;
      dig_q   <= '0;
    end else begin
      dig_v <= 1'b0;
      case (st)
        S_IDLE: if (acc && !skip) begin
          err_q   <= 1'b0;
          alg_q   <= alg_sel;
          first_q <= 1'b1;
          fill    <= in_empty ? '0 : CW'(1);
          term_q  <= in_last;
          st      <= in_last ? S_SUB : S_FILL;
        end
        S_FILL: begin
          if (in_valid && full && !in_empty) begin
            term_q <= 1'b0;
            st     <= S_SUB;
          end else if (acc) begin
            if (!in_empty) fill <= fill + CW'(1);
            if (in_last) begin
              term_q <= 1'b1;
              st     <= S_SUB;
            end
          end
        end
        S_SUB: if (sub_ready) begin
          first_q <= 1'b0;
          st      <= S_WAIT;
        end
        default: if (done_valid) begin
          fill <= '0;
          if (done_err) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (term_q) begin
            dig_v <= 1'b1;
            dig_q <= rev;
            st    <= S_IDLE;
          end else begin
            st <= S_FILL;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hash_chunk_seq_chk.sv
module hash_chunk_seq_chk #(
  parameter int BUF_BYTES = 4096
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           in_empty,
  input logic                           buf_we,
  input logic                           sub_valid,
  input logic                           sub_ready,
  input logic [$clog2(BUF_BYTES+1)-1:0] sub_len,
  input logic                           sub_init,
  input logic                           sub_term,
  input logic [31:0]                    sub_ctrl1,
  input logic                           dig_valid,
  input logic [5:0]                     dig_len,
  input logic                           err_flag
);
  assert_write_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (in_valid && in_ready && !in_empty));
  assert_partial_only_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_term) |-> (sub_len == BUF_BYTES));
  assert_request_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_len) && $stable(sub_term) && $stable(sub_init)));
  assert_alg_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (sub_ctrl1 == 32'h0 || sub_ctrl1 == 32'h0002_0000));
  assert_digest_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (dig_len == 6'd20 || dig_len == 6'd32));
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (in_ready && !sub_valid));
  assert_stall_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> !in_ready);
endmodule

bind hash_chunk_seq hash_chunk_seq_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_empty(in_empty), .buf_we(buf_we), .sub_valid(sub_valid),
  .sub_ready(sub_ready), .sub_len(sub_len), .sub_init(sub_init),
  .sub_term(sub_term), .sub_ctrl1(sub_ctrl1), .dig_valid(dig_valid),
  .dig_len(dig_len), .err_flag(err_flag)
);

// File: tb/hash_chunk_seq_bench.sv
module hash_chunk_seq_bench;
  localparam int BUF = 4096;
  localparam int CW = $clog2(BUF + 1);
  localparam int AW = $clog2(BUF);
  // n, alg, empties, errcase, hold_at_full
  localparam int TAB [7][5] = '{
    '{5, 0, 1, 0, 0}, '{4096, 1, 0, 0, 0}, '{4097, 0, 0, 0, 1},
    '{8192, 1, 1, 0, 0}, '{0, 1, 0, 0, 0}, '{4097, 0, 0, 1, 0},
    '{9000, 1, 0, 0, 0}};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_empty = 0, in_last = 0, alg_sel = 0;
  logic [7:0] in_data = 0;
  logic sub_ready = 0, done_valid = 0, done_err = 0;
  logic [255:0] core_digest = 0;
  logic in_ready, buf_we, sub_valid, sub_init, sub_term, dig_valid, err_flag;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [CW-1:0] sub_len;
  logic [31:0] sub_ctrl1;
  logic [255:0] dig_data;
  logic [5:0] dig_len;

  always #4 clk = ~clk;

  hash_chunk_seq #(.BUF_BYTES(BUF)) u_hash_chunk_seq (.*);

  int checks = 0, errors = 0;
  int rec_n = 0, rec_len [64], rec_init [64], rec_term [64], rec_alg [64];
  int dig_cnt = 0, err_cnt = 0, lat = 0, pend = 0, err_at = -1;
  logic hold = 0, err_prev = 0;
  logic [255:0] dig_seen;
  int wr_err = 0, last_stalls = 0;

  always @(negedge clk) begin
    if (done_valid) done_valid = 0;
    if (dig_valid) begin dig_cnt++; dig_seen = dig_data; end
    if (err_flag && !err_prev) err_cnt++;
    err_prev = err_flag;
    if (sub_ready) sub_ready = 0;
    else if (sub_valid) begin
      if (hold) begin
        if (rec_n < 64) begin
          rec_len[rec_n] = int'(sub_len); rec_init[rec_n] = int'(sub_init);
          rec_term[rec_n] = int'(sub_term); rec_alg[rec_n] = int'(sub_ctrl1[19:16]);
        end
        pend = rec_n; rec_n++;
        sub_ready = 1; hold = 0; lat = 4;
      end else hold = 1;
    end
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin done_valid = 1; done_err = (pend == err_at); end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic send(input logic [7:0] d, input logic e, input logic l, input int addr);
    @(negedge clk);
    in_valid = 1; in_data = d; in_empty = e; in_last = l;
    #1;
    last_stalls = 0;
    while (!in_ready) begin last_stalls++; @(negedge clk); #1; end
    if (!e && !(buf_we && int'(buf_addr) == addr && buf_wdata == d)) wr_err++;
    if (e && buf_we) wr_err++;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic run(input int n, input int alg, input int emp, input int ec, input int hf, input int salt);
    int base, d0, k, nb, lenx, r0;
    logic [255:0] exp;
    base = rec_n; d0 = dig_cnt; r0 = err_cnt; wr_err = 0;
    alg_sel = alg[0];
    for (int b = 0; b < 32; b++) core_digest[b*8 +: 8] = 8'(b * 3 + salt);
    err_at = ec ? base : -1;
    if (emp) send(0, 1, 0, 0);
    if (n == 0) send(0, 1, 1, 0);
    for (int i = 0; i < n; i++) begin
      if (emp && i == 1) send(0, 1, 0, 0);
      if (hf && i == BUF) begin
        repeat (20) @(negedge clk);
        chk(rec_n == base, "R3 full buffer held without further data", rec_n - base, 0);
      end
      send(8'(i ^ salt), 0, i == n - 1, i % BUF);
      if (hf && i == BUF) chk(last_stalls > 0, "R11 byte stalled during chunk", last_stalls, 1);
    end
    for (int t = 0; t < 200 && dig_cnt == d0; t++) @(negedge clk);
    chk(dig_cnt == d0 + 1, "R7 digest delivered", dig_cnt - d0, 1);
    chk(wr_err == 0, "R2 R8 R9 staging writes", wr_err, 0);
    if (ec) begin
      chk(err_cnt == r0 + 1, "R10 error raised", err_cnt - r0, 1);
      chk(err_flag == 0, "R10 error cleared by new session", int'(err_flag), 0);
      chk(rec_n - base == 2, "R10 chunk count", rec_n - base, 2);
      chk(rec_len[base+1] == 1 && rec_init[base+1] == 1 && rec_term[base+1] == 1,
          "R4 R5 session after abort", rec_len[base+1], 1);
      nb = alg ? 32 : 20;
    end else begin
      k = (n == 0) ? 1 : (n + BUF - 1) / BUF;
      chk(rec_n - base == k, "R3 chunk count", rec_n - base, k);
      for (int j = 0; j < k && base + j < 64; j++) begin
        lenx = (j < k - 1) ? BUF : n - (k - 1) * BUF;
        chk(rec_len[base+j] == lenx, "R5 R9 chunk length", rec_len[base+j], lenx);
        chk(rec_init[base+j] == (j == 0 ? 1 : 0), "R4 init flag", rec_init[base+j], j == 0 ? 1 : 0);
        chk(rec_term[base+j] == (j == k - 1 ? 1 : 0), "R5 terminate flag", rec_term[base+j], j == k - 1 ? 1 : 0);
        chk(rec_alg[base+j] == (alg ? 2 : 0), "R6 algorithm code", rec_alg[base+j], alg ? 2 : 0);
      end
      nb = alg ? 32 : 20;
    end
    exp = '0;
    for (int b = 0; b < nb; b++) exp[b*8 +: 8] = 8'((nb - 1 - b) * 3 + salt);
    chk(dig_seen == exp, "R7 reversed digest", int'(dig_seen[7:0]), int'(exp[7:0]));
    chk(int'(dig_len) == nb, "R7 digest length", int'(dig_len), nb);
  endtask

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(in_ready == 1 && sub_valid == 0 && dig_valid == 0 && err_flag == 0,
        "R1 reset state", {in_ready, sub_valid, dig_valid, err_flag}, 4'b1000);
    r = rec_n;
    send(0, 1, 0, 0);
    repeat (10) @(negedge clk);
    chk(rec_n == r && sub_valid == 0, "R8 lone empty beat ignored", rec_n - r, 0);
    for (int v = 0; v < 7; v++) run(TAB[v][0], TAB[v][1], TAB[v][2], TAB[v][3], TAB[v][4], 17 + v * 11);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule